// File: doc/BRIEF.md
# Direct Page Address Expansion Unit

This block holds an 8-bit direct page register and uses it to turn a short direct-mode operand into a full address. A direct-mode access supplies only an 8-bit offset. The unit places the register contents above that offset to form a 16-bit local address. It also forms a 23-bit global address. For a global instruction, the top seven bits come from a global page input. For any other access, they come from a fixed local-to-global mapping input.

Software reaches the register through a small register port with select, write enable, write data and read data. In special mode, the register can be rewritten as often as needed. In normal mode, the register takes the first write after reset and then refuses all later writes until the next reset. Accesses that are not in direct mode pass their 16-bit address through unchanged, and the direct-mode indication stays low for them.

Top module: `dpx_unit`

## Requirements
- R1: After reset the direct page register reads 0x00.
- R2: reg_rdata shows the register value in every cycle, whether or not reg_sel is high.
- R3: With special_mode high, every write (reg_sel and reg_we high) loads reg_wdata into the register.
- R4: With special_mode low, only the first write after reset loads the register, and every later normal-mode write leaves it unchanged.
- R5: Writes made in special mode do not use up the single normal-mode write.
- R6: A write takes effect at the clock edge that ends the write cycle, so an access in that same cycle still uses the old register value.
- R7: For a direct access without the global flag, out_local is {register, operand}, out_global is {lmap_page, register, operand}, and out_direct is 1.
- R8: For a direct access with the global flag, out_global is {gpage, register, operand}. For example, gpage 0x14 with register 0x80 and operand 0x00 gives 0x148000.
- R9: For a non-direct access, out_local equals acc_addr, out_global is {lmap_page, acc_addr}, and out_direct is 0.
- R10: A cycle with reg_sel low or reg_we low leaves the register unchanged.
- R11: Only reset clears the write lock; after a new reset, one normal-mode write is accepted again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| special_mode | input | 1 | 1 = special mode (unlimited writes), 0 = normal mode |
| reg_sel | input | 1 | Register port select |
| reg_we | input | 1 | Register port write enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Current direct page value |
| acc_direct | input | 1 | Access uses direct addressing |
| acc_global | input | 1 | Access is a global instruction |
| acc_operand | input | 8 | Direct-mode operand (low address byte) |
| acc_addr | input | 16 | Full address for non-direct accesses |
| gpage | input | 7 | Global page value |
| lmap_page | input | 7 | Fixed local-to-global upper bits |
| out_local | output | 16 | Formed local address |
| out_global | output | 23 | Formed global address |
| out_direct | output | 1 | Direct-mode indication |

## Verification
The bench checks the write lock from several angles. It makes a second normal-mode write, which a design with no lock would accept. It makes special-mode writes before the first normal write, which a design that counts every write would treat as the lock being used up. It applies a new reset, which a design with a sticky lock would ignore. It also places a write and a direct access in the same cycle. A design that forwards the write data would show the new page in that cycle instead of the old one. Finally, it toggles the global flag and the direct flag with the operand fixed. A design that mixes up the two upper-bit sources, or leaks the direct indication onto pass-through accesses, would fail these checks.

// File: rtl/dpx_pkg.sv
package dpx_pkg;

  // Which address source feeds the formed outputs
  typedef enum logic [1:0] {
    ACC_PASS   = 2'd0,  // full address passes through
    ACC_LOCAL  = 2'd1,  // direct mode, mapped upper bits
    ACC_GLOBAL = 2'd2   // direct mode, global page upper bits
  } acc_kind_e;

  // Write lock state for normal mode
  typedef enum logic {
    LOCK_OPEN = 1'b0,
    LOCK_USED = 1'b1
  } lock_e;

endpackage

// File: rtl/dpx_rst_sync.sv
module dpx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_q_n = sync_q[STAGES-1];

endmodule

// File: rtl/dpx_page_reg.sv
module dpx_page_reg
  import dpx_pkg::*;
#(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              special_mode,
  input  logic              reg_sel,
  input  logic              reg_we,
  input  logic [PAGE_W-1:0] reg_wdata,
  output logic [PAGE_W-1:0] page_q
);

  lock_e             lock_q;
  lock_e             lock_d;
  logic [PAGE_W-1:0] page_d;
  logic              wr_req;
  logic              wr_en;
  logic              lock_en;

  // Write request and the lock check
  always_comb begin
    wr_req  = reg_sel & reg_we;
    wr_en   = wr_req & (special_mode | (lock_q == LOCK_OPEN));
    lock_en = wr_en & ~special_mode;
  end

  // Next-state logic
  always_comb begin
    page_d = page_q;
    lock_d = lock_q;
    if (wr_en) begin
      page_d = reg_wdata;
    end
    if (lock_en) begin
      lock_d = LOCK_USED;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
    end else if (wr_en) begin
      page_q <= page_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= LOCK_OPEN;
    end else if (lock_en) begin
      lock_q <= lock_d;
    end
  end

endmodule

// File: rtl/dpx_addr_form.sv
module dpx_addr_form
  import dpx_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int OFS_W  = 8,
  parameter int GP_W   = 7,
  localparam int LOC_W = PAGE_W + OFS_W,
  localparam int GLB_W = GP_W + LOC_W
) (
  input  logic [PAGE_W-1:0] page,
  input  logic              acc_direct,
  input  logic              acc_global,
  input  logic [OFS_W-1:0]  acc_operand,
  input  logic [LOC_W-1:0]  acc_addr,
  input  logic [GP_W-1:0]   gpage,
  input  logic [GP_W-1:0]   lmap_page,
  output logic [LOC_W-1:0]  out_local,
  output logic [GLB_W-1:0]  out_global,
  output logic              out_direct
);

  acc_kind_e        kind;
  logic [GP_W-1:0]  upper;
  logic [LOC_W-1:0] low_part;

  always_comb begin
    if (!acc_direct) begin
      kind = ACC_PASS;
    end else if (acc_global) begin
      kind = ACC_GLOBAL;
    end else begin
      kind = ACC_LOCAL;
    end
  end

  always_comb begin
    low_part = acc_addr;
    upper    = lmap_page;
    case (kind)
      ACC_LOCAL: begin
        low_part = {page, acc_operand};
      end
      ACC_GLOBAL: begin
        low_part = {page, acc_operand};
        upper    = gpage;
      end
      default: begin
        low_part = acc_addr;
      end
    endcase
  end

  assign out_local  = low_part;
  assign out_global = {upper, low_part};
  assign out_direct = (kind != ACC_PASS);

endmodule

// File: rtl/dpx_unit.sv
module dpx_unit #(
  parameter int PAGE_W      = 8,
  parameter int OFS_W       = 8,
  parameter int GP_W        = 7,
  parameter int SYNC_STAGES = 2,
  localparam int LOC_W      = PAGE_W + OFS_W,
  localparam int GLB_W      = GP_W + LOC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              special_mode,
  input  logic              reg_sel,
  input  logic              reg_we,
  input  logic [PAGE_W-1:0] reg_wdata,
  output logic [PAGE_W-1:0] reg_rdata,
  input  logic              acc_direct,
  input  logic              acc_global,
  input  logic [OFS_W-1:0]  acc_operand,
  input  logic [LOC_W-1:0]  acc_addr,
  input  logic [GP_W-1:0]   gpage,
  input  logic [GP_W-1:0]   lmap_page,
  output logic [LOC_W-1:0]  out_local,
  output logic [GLB_W-1:0]  out_global,
  output logic              out_direct
);

  logic              rst_q_n;
  logic [PAGE_W-1:0] page_q;

  dpx_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  dpx_page_reg #(
    .PAGE_W (PAGE_W)
  ) u_page_reg (
    .clk          (clk),
    .rst_n        (rst_q_n),
    .special_mode (special_mode),
    .reg_sel      (reg_sel),
    .reg_we       (reg_we),
    .reg_wdata    (reg_wdata),
    .page_q       (page_q)
  );

  dpx_addr_form #(
    .PAGE_W (PAGE_W),
    .OFS_W  (OFS_W),
    .GP_W   (GP_W)
  ) u_addr_form (
    .page        (page_q),
    .acc_direct  (acc_direct),
    .acc_global  (acc_global),
    .acc_operand (acc_operand),
    .acc_addr    (acc_addr),
    .gpage       (gpage),
    .lmap_page   (lmap_page),
    .out_local   (out_local),
    .out_global  (out_global),
    .out_direct  (out_direct)
  );

  assign reg_rdata = page_q;

endmodule

// File: rtl/dpx_unit_chk.sv
module dpx_unit_chk #(
  parameter int PAGE_W = 8,
  parameter int OFS_W  = 8,
  parameter int GP_W   = 7,
  localparam int LOC_W = PAGE_W + OFS_W,
  localparam int GLB_W = GP_W + LOC_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              special_mode,
  input logic              reg_sel,
  input logic              reg_we,
  input logic [PAGE_W-1:0] reg_wdata,
  input logic [PAGE_W-1:0] reg_rdata,
  input logic              acc_direct,
  input logic              acc_global,
  input logic [OFS_W-1:0]  acc_operand,
  input logic [LOC_W-1:0]  acc_addr,
  input logic [GP_W-1:0]   gpage,
  input logic [GP_W-1:0]   lmap_page,
  input logic [LOC_W-1:0]  out_local,
  input logic [GLB_W-1:0]  out_global,
  input logic              out_direct
);

  p_special_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (special_mode && reg_sel && reg_we) |=> (reg_rdata == $past(reg_wdata)));

  p_no_write_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_sel && reg_we) |=> $stable(reg_rdata));

  p_direct_local_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_direct && !acc_global) |->
      (out_local == {reg_rdata, acc_operand}) &&
      (out_global[GLB_W-1:LOC_W] == lmap_page) && out_direct);

  p_direct_global_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_direct && acc_global) |->
      (out_global == {gpage, reg_rdata, acc_operand}) && out_direct);

  p_pass_through_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_direct |->
      (out_local == acc_addr) && (out_global == {lmap_page, acc_addr}) && !out_direct);

endmodule

bind dpx_unit dpx_unit_chk #(
  .PAGE_W (PAGE_W),
  .OFS_W  (OFS_W),
  .GP_W   (GP_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_q_n),
  .special_mode (special_mode),
  .reg_sel      (reg_sel),
  .reg_we       (reg_we),
  .reg_wdata    (reg_wdata),
  .reg_rdata    (reg_rdata),
  .acc_direct   (acc_direct),
  .acc_global   (acc_global),
  .acc_operand  (acc_operand),
  .acc_addr     (acc_addr),
  .gpage        (gpage),
  .lmap_page    (lmap_page),
  .out_local    (out_local),
  .out_global   (out_global),
  .out_direct   (out_direct)
);

// File: tb/dpx_unit_tb.sv
module dpx_unit_tb;

  logic        clk;
  logic        rst_n;
  logic        special_mode;
  logic        reg_sel;
  logic        reg_we;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        acc_direct;
  logic        acc_global;
  logic [7:0]  acc_operand;
  logic [15:0] acc_addr;
  logic [6:0]  gpage;
  logic [6:0]  lmap_page;
  logic [15:0] out_local;
  logic [22:0] out_global;
  logic        out_direct;

  int checks;
  int errors;
  bit done;

  dpx_unit u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .special_mode (special_mode),
    .reg_sel      (reg_sel),
    .reg_we       (reg_we),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .acc_direct   (acc_direct),
    .acc_global   (acc_global),
    .acc_operand  (acc_operand),
    .acc_addr     (acc_addr),
    .gpage        (gpage),
    .lmap_page    (lmap_page),
    .out_local    (out_local),
    .out_global   (out_global),
    .out_direct   (out_direct)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    reg_sel = 0; reg_we = 0; reg_wdata = 0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  // one write cycle, driven at negedge, result visible at the next negedge
  task automatic wr(input logic mode, input logic sel, input logic we, input logic [7:0] d);
    @(negedge clk);
    special_mode = mode; reg_sel = sel; reg_we = we; reg_wdata = d;
    @(negedge clk);
    reg_sel = 0; reg_we = 0; reg_wdata = 8'h5A;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 reset value", reg_rdata, 8'h00);
  endtask

  task automatic t_read_anytime();
    wr(1, 1, 1, 8'h3C);
    reg_sel = 0;
    #1 check("R2 read without select", reg_rdata, 8'h3C);
    reg_sel = 1;
    #1 check("R2 read with select", reg_rdata, 8'h3C);
    reg_sel = 0;
  endtask

  task automatic t_special();
    do_reset();
    wr(1, 1, 1, 8'h11);
    check("R3 special write 1", reg_rdata, 8'h11);
    wr(1, 1, 1, 8'hA7);
    check("R3 special write 2", reg_rdata, 8'hA7);
    wr(1, 1, 1, 8'hFF);
    check("R3 special write 3", reg_rdata, 8'hFF);
  endtask

  task automatic t_normal_lock();
    do_reset();
    wr(0, 1, 1, 8'h42);
    check("R4 first normal write", reg_rdata, 8'h42);
    wr(0, 1, 1, 8'h99);
    check("R4 second normal write ignored", reg_rdata, 8'h42);
    wr(0, 1, 1, 8'h00);
    check("R4 third normal write ignored", reg_rdata, 8'h42);
  endtask

  task automatic t_special_then_normal();
    do_reset();
    wr(1, 1, 1, 8'h21);
    wr(1, 1, 1, 8'h22);
    wr(0, 1, 1, 8'h77);
    check("R5 normal write after special writes", reg_rdata, 8'h77);
    wr(0, 1, 1, 8'h78);
    check("R5 lock after that normal write", reg_rdata, 8'h77);
  endtask

  task automatic t_same_cycle();
    do_reset();
    wr(1, 1, 1, 8'h10);
    @(negedge clk);
    special_mode = 1; reg_sel = 1; reg_we = 1; reg_wdata = 8'hC3;
    acc_direct = 1; acc_global = 0; acc_operand = 8'h05;
    #1 check("R6 same-cycle access uses old page", out_local, 16'h1005);
    @(negedge clk);
    reg_sel = 0; reg_we = 0;
    #1 check("R6 next cycle uses new page", out_local, 16'hC305);
  endtask

  task automatic t_direct_local();
    wr(1, 1, 1, 8'h80);
    acc_direct = 1; acc_global = 0; acc_operand = 8'h3E;
    gpage = 7'h14; lmap_page = 7'h7F; acc_addr = 16'hBEEF;
    #1;
    check("R7 local address", out_local, 16'h803E);
    check("R7 global with mapped upper", out_global, 23'h7F803E);
    check("R7 direct flag", out_direct, 1'b1);
  endtask

  task automatic t_direct_global();
    wr(1, 1, 1, 8'h80);
    acc_direct = 1; acc_global = 1; acc_operand = 8'h00;
    gpage = 7'h14; lmap_page = 7'h7F;
    #1;
    check("R8 global example", out_global, 23'h148000);
    check("R8 direct flag", out_direct, 1'b1);
    gpage = 7'h6B; acc_operand = 8'hFE;
    #1 check("R8 global other page", out_global, {7'h6B, 8'h80, 8'hFE});
  endtask

  task automatic t_pass();
    acc_direct = 0; acc_global = 1; acc_addr = 16'h1234; lmap_page = 7'h3F; gpage = 7'h01;
    #1;
    check("R9 local pass-through", out_local, 16'h1234);
    check("R9 global pass-through", out_global, {7'h3F, 16'h1234});
    check("R9 no direct flag", out_direct, 1'b0);
  endtask

  task automatic t_no_select();
    do_reset();
    wr(1, 0, 1, 8'hE1);
    check("R10 write without select ignored", reg_rdata, 8'h00);
    wr(1, 1, 0, 8'hE2);
    check("R10 select without write enable ignored", reg_rdata, 8'h00);
    wr(0, 0, 1, 8'hE3);
    wr(0, 1, 1, 8'h66);
    check("R10 unselected normal write did not lock", reg_rdata, 8'h66);
  endtask

  task automatic t_relock();
    do_reset();
    wr(0, 1, 1, 8'h31);
    wr(0, 1, 1, 8'h32);
    check("R11 locked before reset", reg_rdata, 8'h31);
    do_reset();
    check("R11 reset clears page", reg_rdata, 8'h00);
    wr(0, 1, 1, 8'h55);
    check("R11 normal write accepted after reset", reg_rdata, 8'h55);
  endtask

  initial begin
    checks = 0; errors = 0; done = 0;
    rst_n = 0; special_mode = 1; reg_sel = 0; reg_we = 0; reg_wdata = 0;
    acc_direct = 0; acc_global = 0; acc_operand = 0; acc_addr = 0;
    gpage = 0; lmap_page = 0;
    t_reset();
    t_read_anytime();
    t_special();
    t_normal_lock();
    t_special_then_normal();
    t_same_cycle();
    t_direct_local();
    t_direct_global();
    t_pass();
    t_no_select();
    t_relock();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule